// File: doc/BRIEF.md
# UART Software Flow Control Engine

This block adds XON/XOFF software flow control to a UART. It sits beside the transmitter, the receive FIFO and the receive character path. On the transmit side it watches a level signal that is high while the receive FIFO is at or above its trigger threshold. On each crossing it queues one stop or go character and asks the transmitter to insert it into the outgoing stream. On the receive side every incoming character is compared against four programmable codes. A recognised stop code pauses the local transmitter and a recognised go code resumes it. Flow characters that are recognised are removed from the stream written to the receive FIFO.

A 4-bit mode input sets the behaviour. Bits [3:2] set what is sent and bits [1:0] set what is compared. Each direction can use a single code or a two-character sequence. A separate enable for automatic half-duplex direction control shuts software flow control off entirely. While that enable is set, the block drives the transceiver direction output from the TX FIFO's data-pending flag only, so a pending XON/XOFF can never turn the line around. Received characters are assumed to arrive at least two clock cycles apart, which any UART bit rate satisfies.

Transmit FSM states: `TX_IDLE` (nothing to send), `TX_FIRST` (first or only flow character offered), `TX_SECOND` (second character of a pair offered). Transitions: IDLE→FIRST when a stop or go is queued and sending is enabled; FIRST→SECOND on acknowledge in pair mode; FIRST→IDLE on acknowledge in single mode; SECOND→IDLE on acknowledge; any state→IDLE while inhibited. Receive FSM states: `RX_HUNT` (no partial match), `RX_HOLD_ON` (first go code seen and held back), `RX_HOLD_OFF` (first stop code seen and held back). Transitions: HUNT→HOLD_ON or HUNT→HOLD_OFF on a first code in sequence mode; HOLD→HUNT on the next character, which either completes the match or releases both characters as data; HOLD→HUNT with release when sequence mode is left.

Top module: `uart_swflow`

## Requirements
- R1: With mode[3:2] = 10, reaching the threshold inserts stop code 1 (`code_off1_i`) once, and falling below it inserts go code 1 (`code_on1_i`) once.
- R2: With mode[3:2] = 01, the inserted characters are stop code 2 (`code_off2_i`) and go code 2 (`code_on2_i`).
- R3: With mode[3:2] = 11, a stop is sent as stop code 1 then stop code 2, and a go as go code 1 then go code 2, each as two successive insertions.
- R4: With mode[3:2] = 00, threshold crossings cause no insertion request.
- R5: Each threshold crossing queues its character at most once; holding the level after the insertion produces no further request.
- R6: With mode[1:0] = 10 (codes 1) or 01 (codes 2), a received matching stop code sets `pause_o` and a matching go code clears it; matched codes are not written out, and every other character is written out unchanged on `rx_wr_o`/`rx_wr_char_o` one cycle after its strobe.
- R7: With mode[1:0] = 11 and mode[3:2] = 10 or 01, either stop code counts as stop and either go code counts as go.
- R8: With mode[1:0] = 11 and mode[3:2] = 11 or 00, only the sequence code 1 then code 2 is recognised; a first code followed by any other character releases both as data, in arrival order, on two consecutive cycles.
- R9: A recognised stop sets `pause_o` only in a cycle after `tx_idle_i` is high; a recognised go clears it. With mode[1:0] = 00, `pause_o` is held low and all characters pass.
- R10: While `hdx_en_i` is high there are no insertion requests, no comparisons (all characters pass) and `pause_o` is low.
- R11: `dir_tx_o` is high exactly when `hdx_en_i` and `tx_data_pend_i` are both high.
- R12: After reset `ins_req_o`, `pause_o`, `rx_wr_o` and `dir_tx_o` are low.
- R13: An insertion request holds `ins_req_o` and `ins_char_o` steady until `ins_ack_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 4 | [3:2] send mode, [1:0] compare mode |
| hdx_en_i | input | 1 | Automatic half-duplex direction control enable |
| code_on1_i | input | 8 | Go code 1 |
| code_on2_i | input | 8 | Go code 2 |
| code_off1_i | input | 8 | Stop code 1 |
| code_off2_i | input | 8 | Stop code 2 |
| rx_level_hi_i | input | 1 | Receive FIFO at or above trigger threshold |
| rx_stb_i | input | 1 | Received character valid |
| rx_char_i | input | 8 | Received character |
| tx_idle_i | input | 1 | Transmitter has no character in progress |
| tx_data_pend_i | input | 1 | TX FIFO holds data characters |
| ins_ack_i | input | 1 | Transmitter accepts the offered flow character |
| ins_req_o | output | 1 | Flow character insertion request |
| ins_char_o | output | 8 | Flow character to insert |
| pause_o | output | 1 | Transmitter pause |
| rx_wr_o | output | 1 | Write strobe toward receive FIFO |
| rx_wr_char_o | output | 8 | Character to write to receive FIFO |
| dir_tx_o | output | 1 | Transceiver direction, high for transmit |

## Verification
Threshold toggling is tried under all four send modes, which separates the code-1, code-2, paired and silent variants, and a held level separates single queuing from repeated queuing. A stalled acknowledge shows whether the request holds. Received streams mix matching codes, codes of the other set and ordinary bytes under each compare mode, so a wrongly selected code set shows up as a passed or dropped character. In sequence mode a broken pair checks that both held characters come back in order. A random byte stream with seeded codes interleaved is compared against a bench model of the drop and pause rules, and the half-duplex enable is checked to shut down both directions.

// File: rtl/swf_pkg.sv
package swf_pkg;
    typedef enum logic [1:0] {
        TX_IDLE   = 2'd0,
        TX_FIRST  = 2'd1,
        TX_SECOND = 2'd2
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_HUNT     = 2'd0,
        RX_HOLD_ON  = 2'd1,
        RX_HOLD_OFF = 2'd2
    } rx_state_e;
endpackage

// File: rtl/swf_tx_inserter.sv
module swf_tx_inserter
    import swf_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inhibit,
    input  logic [1:0]    txm,
    input  logic          level_hi,
    input  logic [CW-1:0] on1,
    input  logic [CW-1:0] on2,
    input  logic [CW-1:0] off1,
    input  logic [CW-1:0] off2,
    input  logic          ack,
    output logic          req,
    output logic [CW-1:0] chr
);
    tx_state_e state, nxt;
    logic      lvl_q, want_off, want_on, kind_off;
    logic      enabled, rise, fall, start;

    assign enabled = !inhibit && (txm != 2'b00);
    assign rise    = level_hi && !lvl_q;
    assign fall    = !level_hi && lvl_q;
    assign start   = (state == TX_IDLE) && (nxt == TX_FIRST);

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:   if (enabled && (want_off || want_on)) nxt = TX_FIRST;
            TX_FIRST:  if (inhibit) nxt = TX_IDLE;
                       else if (ack) nxt = (txm == 2'b11) ? TX_SECOND : TX_IDLE;
            TX_SECOND: if (inhibit || ack) nxt = TX_IDLE;
            default:   nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q    <= 1'b0;
            want_off <= 1'b0;
            want_on  <= 1'b0;
            kind_off <= 1'b0;
        end else begin
            lvl_q <= level_hi;
            if (!enabled) begin
                want_off <= 1'b0;
                want_on  <= 1'b0;
            end else begin
                if (start) begin
                    kind_off <= want_off;
                    if (want_off) want_off <= 1'b0;
                    else          want_on  <= 1'b0;
                end
                if (rise) begin
                    want_off <= 1'b1;
                    want_on  <= 1'b0;
                end else if (fall) begin
                    want_on  <= 1'b1;
                    want_off <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        req = 1'b0;
        chr = '0;
        unique case (state)
            TX_IDLE:   ;
            TX_FIRST: begin
                req = 1'b1;
                if (txm == 2'b01) chr = kind_off ? off2 : on2;
                else              chr = kind_off ? off1 : on1;
            end
            TX_SECOND: begin
                req = 1'b1;
                chr = kind_off ? off2 : on2;
            end
            default:   ;
        endcase
    end
endmodule

// File: rtl/swf_rx_matcher.sv
module swf_rx_matcher
    import swf_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inhibit,
    input  logic [3:0]    mode,
    input  logic          stb,
    input  logic [CW-1:0] ch,
    input  logic [CW-1:0] on1,
    input  logic [CW-1:0] on2,
    input  logic [CW-1:0] off1,
    input  logic [CW-1:0] off2,
    output logic          wr,
    output logic [CW-1:0] wr_ch,
    output logic          hit_on,
    output logic          hit_off
);
    rx_state_e     state, nxt;
    logic [1:0]    rxm, txm;
    logic          pair_mode, off_hit, on_hit;
    logic          do_wr, do_rep, do_hold, d_on, d_off;
    logic [CW-1:0] wr_val, held, rep_c;
    logic          rep_v;

    assign rxm       = inhibit ? 2'b00 : mode[1:0];
    assign txm       = mode[3:2];
    assign pair_mode = (rxm == 2'b11) && ((txm == 2'b11) || (txm == 2'b00));
    assign off_hit   = (rxm[1] && ch == off1) || (rxm[0] && ch == off2);
    assign on_hit    = (rxm[1] && ch == on1) || (rxm[0] && ch == on2);

    always_comb begin
        nxt     = state;
        do_wr   = 1'b0;
        do_rep  = 1'b0;
        do_hold = 1'b0;
        d_on    = 1'b0;
        d_off   = 1'b0;
        wr_val  = ch;
        unique case (state)
            RX_HUNT: if (stb) begin
                if (rxm == 2'b00) do_wr = 1'b1;
                else if (pair_mode) begin
                    if (ch == off1)     begin nxt = RX_HOLD_OFF; do_hold = 1'b1; end
                    else if (ch == on1) begin nxt = RX_HOLD_ON;  do_hold = 1'b1; end
                    else do_wr = 1'b1;
                end
                else if (off_hit) d_off = 1'b1;
                else if (on_hit)  d_on  = 1'b1;
                else              do_wr = 1'b1;
            end
            RX_HOLD_ON, RX_HOLD_OFF: begin
                if (stb) begin
                    nxt = RX_HUNT;
                    if (pair_mode && state == RX_HOLD_OFF && ch == off2) d_off = 1'b1;
                    else if (pair_mode && state == RX_HOLD_ON && ch == on2) d_on = 1'b1;
                    else begin
                        do_wr  = 1'b1;
                        wr_val = held;
                        do_rep = 1'b1;
                    end
                end else if (!pair_mode) begin
                    nxt    = RX_HUNT;
                    do_wr  = 1'b1;
                    wr_val = held;
                end
            end
            default: nxt = RX_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_HUNT;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr      <= 1'b0;
            wr_ch   <= '0;
            hit_on  <= 1'b0;
            hit_off <= 1'b0;
            held    <= '0;
            rep_v   <= 1'b0;
            rep_c   <= '0;
        end else begin
            wr      <= 1'b0;
            hit_on  <= d_on;
            hit_off <= d_off;
            if (rep_v) begin
                wr    <= 1'b1;
                wr_ch <= rep_c;
                rep_v <= 1'b0;
            end
            if (do_wr) begin
                wr    <= 1'b1;
                wr_ch <= wr_val;
            end
            if (do_rep) begin
                rep_v <= 1'b1;
                rep_c <= ch;
            end
            if (do_hold) held <= ch;
        end
    end
endmodule

// File: rtl/uart_swflow.sv
module uart_swflow #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    mode_i,
    input  logic          hdx_en_i,
    input  logic [CW-1:0] code_on1_i,
    input  logic [CW-1:0] code_on2_i,
    input  logic [CW-1:0] code_off1_i,
    input  logic [CW-1:0] code_off2_i,
    input  logic          rx_level_hi_i,
    input  logic          rx_stb_i,
    input  logic [CW-1:0] rx_char_i,
    input  logic          tx_idle_i,
    input  logic          tx_data_pend_i,
    input  logic          ins_ack_i,
    output logic          ins_req_o,
    output logic [CW-1:0] ins_char_o,
    output logic          pause_o,
    output logic          rx_wr_o,
    output logic [CW-1:0] rx_wr_char_o,
    output logic          dir_tx_o
);
    logic hit_on, hit_off, pause_pend, cmp_off;

    swf_tx_inserter #(.CW(CW)) u_tx (
        .clk(clk), .rst_n(rst_n), .inhibit(hdx_en_i), .txm(mode_i[3:2]),
        .level_hi(rx_level_hi_i), .on1(code_on1_i), .on2(code_on2_i),
        .off1(code_off1_i), .off2(code_off2_i), .ack(ins_ack_i),
        .req(ins_req_o), .chr(ins_char_o)
    );

    swf_rx_matcher #(.CW(CW)) u_rx (
        .clk(clk), .rst_n(rst_n), .inhibit(hdx_en_i), .mode(mode_i),
        .stb(rx_stb_i), .ch(rx_char_i), .on1(code_on1_i), .on2(code_on2_i),
        .off1(code_off1_i), .off2(code_off2_i), .wr(rx_wr_o),
        .wr_ch(rx_wr_char_o), .hit_on(hit_on), .hit_off(hit_off)
    );

    assign cmp_off  = hdx_en_i || (mode_i[1:0] == 2'b00);
    assign dir_tx_o = hdx_en_i && tx_data_pend_i;

    // Stop takes effect only once the character in flight has finished.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pause_o    <= 1'b0;
            pause_pend <= 1'b0;
        end else if (cmp_off || hit_on) begin
            pause_o    <= 1'b0;
            pause_pend <= 1'b0;
        end else if (hit_off) begin
            pause_pend <= 1'b1;
        end else if (pause_pend && tx_idle_i) begin
            pause_o    <= 1'b1;
            pause_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/swf_checker.sv
module swf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] mode_i,
    input logic       hdx_en_i,
    input logic       tx_idle_i,
    input logic       ins_ack_i,
    input logic       ins_req_o,
    input logic [7:0] ins_char_o,
    input logic       pause_o
);
    assert_no_insert_inhibited_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hdx_en_i |=> !ins_req_o);

    assert_req_held_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_req_o && !ins_ack_i && !hdx_en_i) |=> (ins_req_o && $stable(ins_char_o)));

    assert_pause_after_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pause_o) |-> $past(tx_idle_i));

    assert_no_pause_cmp_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i[1:0] == 2'b00) |=> !pause_o);

    assert_silent_send_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i[3:2] == 2'b00 && !ins_req_o) |=> !ins_req_o);
endmodule

bind uart_swflow swf_checker u_chk (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .hdx_en_i(hdx_en_i),
    .tx_idle_i(tx_idle_i), .ins_ack_i(ins_ack_i), .ins_req_o(ins_req_o),
    .ins_char_o(ins_char_o), .pause_o(pause_o)
);

// File: tb/uart_swflow_test.sv
`timescale 1ns/100ps
module uart_swflow_test;
    localparam logic [7:0] ON1 = 8'h11, ON2 = 8'h91, OFF1 = 8'h13, OFF2 = 8'h93;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic [3:0] mode = 4'b0000;
    logic       hdx = 1'b0, lvl = 1'b0, stb = 1'b0, idle = 1'b1, dpend = 1'b0, ack = 1'b0;
    logic [7:0] rch = 8'h00;
    logic       ins_req, pause, wr, dir;
    logic [7:0] ins_char, wr_ch;

    int tests = 0, fails = 0;
    int wr_n;
    logic [7:0] wr_log [0:3];
    bit done = 0;

    always #2.5 clk = ~clk;

    uart_swflow uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .hdx_en_i(hdx),
        .code_on1_i(ON1), .code_on2_i(ON2), .code_off1_i(OFF1), .code_off2_i(OFF2),
        .rx_level_hi_i(lvl), .rx_stb_i(stb), .rx_char_i(rch), .tx_idle_i(idle),
        .tx_data_pend_i(dpend), .ins_ack_i(ack), .ins_req_o(ins_req),
        .ins_char_o(ins_char), .pause_o(pause), .rx_wr_o(wr), .rx_wr_char_o(wr_ch),
        .dir_tx_o(dir)
    );

    task automatic check(input int act, input int exp, input string tag);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Drive one received character and log writes seen in the next three cycles.
    task automatic send_char(input logic [7:0] c);
        @(negedge clk); stb = 1'b1; rch = c;
        @(negedge clk); stb = 1'b0; wr_n = 0;
        for (int i = 0; i < 3; i++) begin
            if (wr) begin wr_log[wr_n] = wr_ch; wr_n++; end
            if (i < 2) @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic expect_ins(input logic [7:0] c, input string tag);
        int n = 0;
        while (!ins_req && n < 20) begin @(negedge clk); n++; end
        check(ins_req, 1, {tag, " request"});
        check(ins_char, c, {tag, " char"});
        ack = 1'b1; @(negedge clk); ack = 1'b0;
    endtask

    task automatic expect_quiet(input int n, input string tag);
        int seen = 0;
        for (int i = 0; i < n; i++) begin @(negedge clk); if (ins_req) seen = 1; end
        check(seen, 0, tag);
    endtask

    // Bench model of single-code compare (mode[1:0] = 10): 1 = drop as stop, 2 = drop as go.
    function automatic int classify10(input logic [7:0] c);
        if (c == OFF1) return 1;
        if (c == ON1)  return 2;
        return 0;
    endfunction

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_up();
    end

    initial begin
        void'($urandom(32'd4711));
        #1;
        // R12 reset state
        check(ins_req, 0, "R12 ins_req"); check(pause, 0, "R12 pause");
        check(wr, 0, "R12 rx_wr");        check(dir, 0, "R12 dir");
        cycles(3); rst_n = 1'b1; cycles(2);

        // R11 direction output
        hdx = 1; dpend = 1; #1 check(dir, 1, "R11 hdx+data");
        dpend = 0; #1 check(dir, 0, "R11 hdx no data");
        hdx = 0; dpend = 1; #1 check(dir, 0, "R11 no hdx"); dpend = 0;
        cycles(2);

        // R1 single code 1, R5 once per crossing
        mode = 4'b1000; lvl = 1; expect_ins(OFF1, "R1 stop");
        expect_quiet(10, "R5 no repeat");
        lvl = 0; expect_ins(ON1, "R1 go");
        expect_quiet(6, "R5 quiet after go");

        // R2 single code 2
        mode = 4'b0100; lvl = 1; expect_ins(OFF2, "R2 stop");
        lvl = 0; expect_ins(ON2, "R2 go");
        expect_quiet(6, "R2 quiet");

        // R3 paired
        mode = 4'b1100; lvl = 1; expect_ins(OFF1, "R3 stop first"); expect_ins(OFF2, "R3 stop second");
        expect_quiet(6, "R3 stop done");
        lvl = 0; expect_ins(ON1, "R3 go first"); expect_ins(ON2, "R3 go second");
        expect_quiet(6, "R3 go done");

        // R13 held request
        mode = 4'b1000; lvl = 1;
        cycles(4); cycles(5);
        check(ins_req, 1, "R13 still requesting"); check(ins_char, OFF1, "R13 char steady");
        expect_ins(OFF1, "R13 accept");
        lvl = 0; expect_ins(ON1, "R13 go");

        // R4 silent send
        mode = 4'b0000; lvl = 1; expect_quiet(8, "R4 mode 00 rise");
        lvl = 0; expect_quiet(8, "R4 mode 00 fall");
        mode = 4'b0011; lvl = 1; expect_quiet(8, "R4 mode 0011"); lvl = 0; cycles(4);

        // R6 single compare, codes 1 then codes 2
        mode = 4'b0010;
        send_char(OFF1); check(wr_n, 0, "R6 stop1 dropped"); check(pause, 1, "R6 pause set");
        send_char(8'h41); check(wr_n, 1, "R6 data passes"); check(wr_log[0], 8'h41, "R6 data value");
        send_char(ON1); check(wr_n, 0, "R6 go1 dropped"); check(pause, 0, "R6 pause cleared");
        send_char(OFF2); check(wr_n, 1, "R6 stop2 passes in codes1 mode"); check(pause, 0, "R6 no pause");
        mode = 4'b0001;
        send_char(OFF2); check(wr_n, 0, "R6 stop2 dropped"); check(pause, 1, "R6 pause codes2");
        send_char(ON2); check(wr_n, 0, "R6 go2 dropped"); check(pause, 0, "R6 resume codes2");

        // R7 either code
        mode = 4'b1011;
        send_char(OFF2); check(pause, 1, "R7 stop2"); check(wr_n, 0, "R7 stop2 dropped");
        send_char(ON1);  check(pause, 0, "R7 go1");
        send_char(OFF1); check(pause, 1, "R7 stop1");
        send_char(ON2);  check(pause, 0, "R7 go2"); check(wr_n, 0, "R7 go2 dropped");

        // R8 sequence compare
        mode = 4'b0011;
        send_char(OFF1); check(wr_n, 0, "R8 first held"); check(pause, 0, "R8 no pause yet");
        send_char(OFF2); check(wr_n, 0, "R8 pair dropped"); check(pause, 1, "R8 pause on pair");
        send_char(ON1); send_char(ON2); check(pause, 0, "R8 resume on pair");
        send_char(ON1); send_char(8'h55);
        check(wr_n, 2, "R8 broken pair count");
        check(wr_log[0], ON1, "R8 held released first"); check(wr_log[1], 8'h55, "R8 second released");
        mode = 4'b1111;
        send_char(OFF2); check(wr_n, 1, "R8 lone stop2 passes"); check(pause, 0, "R8 lone stop2 no pause");

        // R9 pause waits for idle, compare off
        mode = 4'b0010; idle = 0;
        send_char(OFF1); check(pause, 0, "R9 not idle");
        cycles(4); check(pause, 0, "R9 still busy");
        idle = 1; cycles(2); check(pause, 1, "R9 pause after idle");
        mode = 4'b0000; cycles(2); check(pause, 0, "R9 cleared by mode 00");
        send_char(OFF1); check(wr_n, 1, "R9 passes when off"); check(wr_log[0], OFF1, "R9 value");

        // R10 inhibit
        mode = 4'b1010; hdx = 1; lvl = 1; expect_quiet(8, "R10 no insert");
        send_char(OFF1); check(wr_n, 1, "R10 stop passes"); check(pause, 0, "R10 no pause");
        lvl = 0; cycles(3); hdx = 0; cycles(3);

        // R6 random stream against bench model
        begin
            logic exp_p = 1'b0;
            logic [7:0] pick [0:3];
            pick[0] = ON1; pick[1] = OFF1; pick[2] = ON2; pick[3] = OFF2;
            mode = 4'b0010;
            for (int k = 0; k < 40; k++) begin
                logic [7:0] c;
                int cls;
                c = (k % 3 == 0) ? pick[$urandom % 4] : 8'($urandom);
                cls = classify10(c);
                send_char(c);
                if (cls == 1) exp_p = 1'b1;
                if (cls == 2) exp_p = 1'b0;
                check(wr_n, (cls == 0) ? 1 : 0, "R6 random write count");
                if (cls == 0) check(wr_log[0], c, "R6 random value");
                check(pause, exp_p, "R6 random pause");
            end
        end

        finish_up();
    end
endmodule